// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block gives a host indirect access to the internal register space of a serial-link PHY. The PHY exposes a narrow parallel control port: a 16-bit input bus, four request strobes (address capture, data capture, write and read), one acknowledge line and a 16-bit output bus. Each strobe is a four-phase exchange. The master raises the strobe and waits for the acknowledge to go high. It then lowers the strobe and waits for the acknowledge to go low.

The host issues one of four commands with a 2-bit opcode and a 16-bit operand. While a command runs the block reports busy. It ends with a one-cycle done pulse, or with a one-cycle timeout pulse if the PHY fails to answer. The acknowledge is polled rather than watched continuously. The wait between polls is a run-time cycle count, and the number of polls per wait is capped. A write whose held value has bit 0 set resets the PHY, which then cannot answer. That write is therefore issued without any wait.

Top module: `phy_cr_master`

## Requirements
- R1: After reset all four strobes, `phy_din_o`, `rd_data_o`, `busy_o`, `done_o` and `timeout_o` are zero.
- R2: Opcode 0 (address) loads the operand onto `phy_din_o` and raises `phy_cap_addr_o`. After a poll sees ack high it lowers the strobe. After a later poll sees ack low it pulses `done_o`.
- R3: Opcode 1 (data) runs the R2 sequence on `phy_cap_data_o` with the operand as the held value.
- R4: Opcode 2 (write), with bit 0 of the held value clear, runs the full raise/ack-high/lower/ack-low sequence on `phy_wr_o`. It leaves `phy_din_o` unchanged.
- R5: Opcode 2 with bit 0 of the held value set raises `phy_wr_o` and pulses `done_o` in the next cycle without asserting `busy_o`. `phy_wr_o` stays high until the next command is accepted.
- R6: Opcode 3 (read) raises `phy_rd_o`. At the poll that sees ack high it captures `phy_dout_i` into `rd_data_o`, which then holds. It finishes with the deassert handshake.
- R7: The first poll after a strobe changes happens one cycle later. Later polls are separated by `poll_gap_i` cycles without a poll.
- R8: If 10 polls in one wait all miss the expected ack level, `timeout_o` pulses, every strobe is low and the block is idle.
- R9: A command presented while `busy_o` is high is ignored. It does not change `phy_din_o` or the strobes.
- R10: At most one strobe is high at any time, and `done_o` and `timeout_o` are never high together.
- R11: `busy_o` is high from the cycle after a handshaked command is accepted until the cycle in which its done or timeout pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_gap_i | input | 16 | Cycles without a poll between two polls |
| cmd_valid_i | input | 1 | Command request, taken when idle |
| cmd_op_i | input | 2 | 0 address, 1 data, 2 write, 3 read |
| cmd_data_i | input | 16 | Operand for address and data commands |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle abort pulse |
| rd_data_o | output | 16 | Last value captured by a read |
| phy_din_o | output | 16 | Held value driven to the PHY |
| phy_cap_addr_o | output | 1 | Address capture strobe |
| phy_cap_data_o | output | 1 | Data capture strobe |
| phy_wr_o | output | 1 | Write strobe |
| phy_rd_o | output | 1 | Read strobe |
| phy_ack_i | input | 1 | PHY acknowledge |
| phy_dout_i | input | 16 | PHY read data |

## Verification
A command accepted at a rising edge shows its strobe and held value, and raises busy, right after that edge. The first poll comes one edge later. After a poll that misses, the next poll comes `poll_gap_i`+1 edges later. Done, timeout and captured read data appear just after the edge of the deciding poll. A fire-and-forget write pulses done right after the accepting edge. A behavioural model advances on the same edges and sees the same acknowledge values. The bench compares its outputs against the model at every falling edge, so each result is checked in the exact cycle it is due. Directed checks on held value, captured data and pulse timing are sampled at falling edges once the command has settled.

// File: rtl/phy_cr_pkg.sv
`timescale 1ns/1ps
package phy_cr_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_DATA  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } cr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_WAIT_LO = 2'd2
  } cr_state_e;

  localparam int unsigned NUM_STROBES = 4;
endpackage

// File: rtl/phy_cr_poll_timer.sv
`timescale 1ns/1ps
module phy_cr_poll_timer #(
  parameter int unsigned GAP_W     = 16,
  parameter int unsigned MAX_POLLS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             active_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             poll_o,
  output logic             last_o
);
  localparam int unsigned POLL_CW = $clog2(MAX_POLLS + 1);

  logic [GAP_W-1:0]   gap_q;
  logic [POLL_CW-1:0] poll_q;

  assign poll_o = active_i && (gap_q == '0);
  assign last_o = (poll_q == POLL_CW'(MAX_POLLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      poll_q <= '0;
    end else if (restart_i) begin
      gap_q  <= '0;
      poll_q <= '0;
    end else if (poll_o) begin
      // a missed poll: count it and start the gap
      poll_q <= poll_q + 1'b1;
      gap_q  <= gap_i;
    end else if (active_i && gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assert_poll_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (poll_q < POLL_CW'(MAX_POLLS)));
endmodule

// File: rtl/phy_cr_strobe_drv.sv
`timescale 1ns/1ps
module phy_cr_strobe_drv
  import phy_cr_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_i,
  input  cr_op_e                 sel_i,
  input  logic                   drop_i,
  input  logic                   load_din_i,
  input  logic [DW-1:0]          din_i,
  input  logic                   cap_i,
  input  logic [DW-1:0]          dout_i,
  output logic [NUM_STROBES-1:0] strobe_o,
  output logic [DW-1:0]          din_o,
  output logic [DW-1:0]          rd_data_o
);
  logic [NUM_STROBES-1:0] str_q;
  logic [DW-1:0]          din_q;
  logic [DW-1:0]          rd_q;

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      str_q[g] <= 1'b0;
      else if (set_i)   str_q[g] <= (int'(sel_i) == g);
      else if (drop_i)  str_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          din_q <= '0;
    else if (load_din_i)  din_q <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= '0;
    else if (cap_i)  rd_q <= dout_i;
  end

  assign strobe_o  = str_q;
  assign din_o     = din_q;
  assign rd_data_o = rd_q;

  assert_one_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(str_q));
endmodule

// File: rtl/phy_cr_seq.sv
`timescale 1ns/1ps
module phy_cr_seq
  import phy_cr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_valid_i,
  input  cr_op_e cmd_op_i,
  input  logic   held_bit0_i,
  input  logic   ack_i,
  input  logic   poll_i,
  input  logic   last_i,
  output logic   set_o,
  output cr_op_e sel_o,
  output logic   drop_o,
  output logic   load_din_o,
  output logic   cap_o,
  output logic   restart_o,
  output logic   active_o,
  output logic   busy_o,
  output logic   done_o,
  output logic   timeout_o
);
  cr_state_e st_q, st_d;
  cr_op_e    op_q;
  logic      done_d, to_d;
  logic      done_q, to_q;
  logic      accept;

  assign accept = (st_q == ST_IDLE) && cmd_valid_i;

  always_comb begin
    st_d       = st_q;
    set_o      = 1'b0;
    drop_o     = 1'b0;
    load_din_o = 1'b0;
    cap_o      = 1'b0;
    restart_o  = 1'b0;
    done_d     = 1'b0;
    to_d       = 1'b0;
    active_o   = (st_q != ST_IDLE);
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          set_o      = 1'b1;
          load_din_o = (cmd_op_i == OP_ADDR) || (cmd_op_i == OP_DATA);
          if (cmd_op_i == OP_WRITE && held_bit0_i) begin
            done_d = 1'b1;  // reset write: PHY cannot answer
          end else begin
            restart_o = 1'b1;
            st_d      = ST_WAIT_HI;
          end
        end
      end
      ST_WAIT_HI: begin
        if (poll_i) begin
          if (ack_i) begin
            drop_o    = 1'b1;
            cap_o     = (op_q == OP_READ);
            restart_o = 1'b1;
            st_d      = ST_WAIT_LO;
          end else if (last_i) begin
            drop_o = 1'b1;
            to_d   = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      ST_WAIT_LO: begin
        if (poll_i) begin
          if (!ack_i) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (last_i) begin
            drop_o = 1'b1;
            to_d   = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_ADDR;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      to_q   <= to_d;
      if (accept) op_q <= cmd_op_i;
    end
  end

  assign sel_o     = cmd_op_i;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;

  assert_pulse_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && to_q));
endmodule

// File: rtl/phy_cr_master.sv
`timescale 1ns/1ps
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned GAP_W     = 16,
  parameter int unsigned MAX_POLLS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GAP_W-1:0] poll_gap_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [DW-1:0]    cmd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [DW-1:0]    rd_data_o,
  output logic [DW-1:0]    phy_din_o,
  output logic             phy_cap_addr_o,
  output logic             phy_cap_data_o,
  output logic             phy_wr_o,
  output logic             phy_rd_o,
  input  logic             phy_ack_i,
  input  logic [DW-1:0]    phy_dout_i
);
  logic                   set_s, drop_s, load_s, cap_s, restart_s, active_s;
  logic                   poll_s, last_s;
  cr_op_e                 sel_s;
  logic [NUM_STROBES-1:0] strobe_s;
  logic [DW-1:0]          din_s;

  phy_cr_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cr_op_e'(cmd_op_i)),
    .held_bit0_i (din_s[0]),
    .ack_i       (phy_ack_i),
    .poll_i      (poll_s),
    .last_i      (last_s),
    .set_o       (set_s),
    .sel_o       (sel_s),
    .drop_o      (drop_s),
    .load_din_o  (load_s),
    .cap_o       (cap_s),
    .restart_o   (restart_s),
    .active_o    (active_s),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
  );

  phy_cr_poll_timer #(
    .GAP_W     (GAP_W),
    .MAX_POLLS (MAX_POLLS)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_s),
    .active_i  (active_s),
    .gap_i     (poll_gap_i),
    .poll_o    (poll_s),
    .last_o    (last_s)
  );

  phy_cr_strobe_drv #(
    .DW (DW)
  ) u_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_s),
    .sel_i      (sel_s),
    .drop_i     (drop_s),
    .load_din_i (load_s),
    .din_i      (cmd_data_i),
    .cap_i      (cap_s),
    .dout_i     (phy_dout_i),
    .strobe_o   (strobe_s),
    .din_o      (din_s),
    .rd_data_o  (rd_data_o)
  );

  assign phy_din_o      = din_s;
  assign phy_cap_addr_o = strobe_s[OP_ADDR];
  assign phy_cap_data_o = strobe_s[OP_DATA];
  assign phy_wr_o       = strobe_s[OP_WRITE];
  assign phy_rd_o       = strobe_s[OP_READ];

  assert_busy_holds_din_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(phy_din_o));

  assert_timeout_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!busy_o && strobe_s == '0));

  assert_done_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(busy_o) || phy_wr_o));

  assert_idle_before_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));
endmodule

// File: tb/phy_cr_master_tb.sv
`timescale 1ns/1ps
module phy_cr_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] gap = 16'd0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_data = 16'd0;
  logic        busy, done, tmo;
  logic [15:0] rd_data, din;
  logic        s_addr, s_data, s_wr, s_rd;
  logic        ack = 1'b0;
  logic [15:0] dout = 16'd0;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  phy_cr_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .poll_gap_i(gap),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
    .busy_o(busy), .done_o(done), .timeout_o(tmo), .rd_data_o(rd_data),
    .phy_din_o(din), .phy_cap_addr_o(s_addr), .phy_cap_data_o(s_data),
    .phy_wr_o(s_wr), .phy_rd_o(s_rd), .phy_ack_i(ack), .phy_dout_i(dout)
  );

  // PHY responder: ack follows any strobe after lat+1 edges, or is stuck
  int ack_lat = 0;
  int ack_mode = 0;  // 0 follow, 1 stuck low, 2 stuck high
  logic [15:0] hist = 16'd0;
  always @(posedge clk) begin
    hist <= {hist[14:0], (s_addr | s_data | s_wr | s_rd)};
    case (ack_mode)
      1: ack <= 1'b0;
      2: ack <= 1'b1;
      default: ack <= (ack_lat == 0) ? (s_addr | s_data | s_wr | s_rd) : hist[ack_lat-1];
    endcase
  end

  // behavioural reference
  int          m_phase, m_tries, m_wait;
  logic [1:0]  m_op;
  logic [15:0] m_din, m_rd;
  logic [3:0]  m_str;
  logic        m_done, m_to;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_tries = 0; m_wait = 0; m_op = 0;
      m_din = 0; m_rd = 0; m_str = 0; m_done = 0; m_to = 0;
    end else begin
      m_done = 0; m_to = 0;
      if (m_phase == 0) begin
        if (cmd_valid) begin
          m_str = 4'b0001 << cmd_op;
          if (cmd_op < 2) m_din = cmd_data;
          if (cmd_op == 2 && m_din[0]) m_done = 1;
          else begin m_phase = 1; m_tries = 0; m_wait = 0; m_op = cmd_op; end
        end
      end else if (m_wait > 0) begin
        m_wait = m_wait - 1;
      end else if (ack == (m_phase == 1)) begin
        if (m_phase == 1) begin
          if (m_op == 3) m_rd = dout;
          m_str = 0; m_phase = 2; m_tries = 0;
        end else begin
          m_done = 1; m_phase = 0;
        end
      end else if (m_tries == 9) begin
        m_to = 1; m_str = 0; m_phase = 0;
      end else begin
        m_tries = m_tries + 1; m_wait = int'(gap);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  bit seen_done, seen_to;
  always @(negedge clk) begin
    if (done) seen_done = 1'b1;
    if (tmo)  seen_to = 1'b1;
    if (rst_n && model_on) begin
      check(busy == (m_phase != 0), cur_req, "busy", 32'(busy), 32'(m_phase != 0));
      check(done == m_done, cur_req, "done", 32'(done), 32'(m_done));
      check(tmo == m_to, cur_req, "timeout", 32'(tmo), 32'(m_to));
      check(din == m_din, cur_req, "din", 32'(din), 32'(m_din));
      check(rd_data == m_rd, cur_req, "rd_data", 32'(rd_data), 32'(m_rd));
      check({s_rd, s_wr, s_data, s_addr} == m_str, cur_req, "strobes",
            32'({s_rd, s_wr, s_data, s_addr}), 32'(m_str));
      check(!(done && tmo), "R10", "pulse overlap", 32'({done, tmo}), 32'(0));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  bit after_busy, after_done, after_wr;
  task automatic run_cmd(input logic [1:0] op, input logic [15:0] data);
    @(negedge clk);
    seen_done = 1'b0; seen_to = 1'b0;
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    after_busy = busy; after_done = done; after_wr = s_wr;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(busy == 0 && done == 0 && tmo == 0, "R1", "flags", 32'({busy, done, tmo}), 32'(0));
    check({s_rd, s_wr, s_data, s_addr} == 0, "R1", "strobes",
          32'({s_rd, s_wr, s_data, s_addr}), 32'(0));
    check(din == 0 && rd_data == 0, "R1", "buses", {din, rd_data}, 32'(0));
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    cur_req = "R2"; gap = 16'd3; ack_lat = 0;
    run_cmd(2'd0, 16'h2003);
    check(after_busy, "R11", "busy after accept", 32'(after_busy), 32'(1));
    check(seen_done && !seen_to, "R2", "address done", 32'({seen_done, seen_to}), 32'(2));
    check(din == 16'h2003, "R2", "held address", 32'(din), 32'h2003);

    cur_req = "R3"; ack_lat = 2;
    run_cmd(2'd1, 16'h00A4);
    check(seen_done, "R3", "data done", 32'(seen_done), 32'(1));
    check(din == 16'h00A4, "R3", "held data", 32'(din), 32'h00A4);

    cur_req = "R4";
    run_cmd(2'd2, 16'hFFFF);
    check(seen_done && din == 16'h00A4, "R4", "write done, din kept", 32'(din), 32'h00A4);
    check(!s_wr, "R4", "write strobe low", 32'(s_wr), 32'(0));

    cur_req = "R6"; dout = 16'hBEEF; ack_lat = 1;
    run_cmd(2'd3, 16'h0000);
    dout = 16'h1111;
    repeat (3) @(negedge clk);
    check(rd_data == 16'hBEEF, "R6", "captured read", 32'(rd_data), 32'hBEEF);

    cur_req = "R7"; gap = 16'd0; ack_lat = 6;
    run_cmd(2'd0, 16'h0017);
    check(seen_done, "R7", "gap 0 done", 32'(seen_done), 32'(1));
    gap = 16'd5; ack_lat = 4;
    run_cmd(2'd1, 16'h0A0A);
    check(seen_done, "R7", "gap 5 done", 32'(seen_done), 32'(1));

    cur_req = "R8"; gap = 16'd2; ack_mode = 1;
    run_cmd(2'd0, 16'h0009);
    check(seen_to && !seen_done, "R8", "stuck low timeout", 32'({seen_to, seen_done}), 32'(2));
    check({s_rd, s_wr, s_data, s_addr} == 0, "R8", "strobes cleared",
          32'({s_rd, s_wr, s_data, s_addr}), 32'(0));
    ack_mode = 2;
    run_cmd(2'd3, 16'h0000);
    check(seen_to, "R8", "stuck high timeout", 32'(seen_to), 32'(1));
    ack_mode = 0; ack_lat = 0;
    repeat (4) @(negedge clk);
    run_cmd(2'd0, 16'h0001);
    check(seen_done, "R8", "recovery after timeout", 32'(seen_done), 32'(1));

    cur_req = "R9"; ack_lat = 6; gap = 16'd4;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 16'h3C3C;
    @(negedge clk);
    cmd_op = 2'd1; cmd_data = 16'h5555;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    check(din == 16'h3C3C && s_addr && !s_data, "R9", "ignored while busy", 32'(din), 32'h3C3C);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(din == 16'h3C3C, "R9", "din after", 32'(din), 32'h3C3C);

    cur_req = "R5"; ack_lat = 0; gap = 16'd1;
    run_cmd(2'd1, 16'h0001);
    run_cmd(2'd2, 16'h0000);
    check(after_done && !after_busy && after_wr, "R5", "reset write immediate",
          32'({after_done, after_busy, after_wr}), 32'(5));
    check(s_wr, "R5", "write strobe held", 32'(s_wr), 32'(1));
    cur_req = "R10";
    run_cmd(2'd0, 16'h7F3F);
    check(!s_wr && seen_done, "R10", "next command clears write", 32'(s_wr), 32'(0));
    cur_req = "R11";
    run_cmd(2'd1, 16'h0002);
    check(after_busy && seen_done, "R11", "busy then done", 32'(after_busy), 32'(1));

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule